// File: doc/BRIEF.md
# Flash Command Decoder and Mode Controller

This block sits behind the host-side bus logic of a parallel flash device. Each time the host completes a bus write, the bus logic hands over a single strobe together with the data and address it latched. The block decodes the low byte of that data as a command and tracks the device mode: array read, identify, status read, write armed, erase armed, write running, erase running, or erase suspended. From the mode it tells the read path which source to drive: the array, the identifier bytes or the status byte.

Writes and erases each need two bus cycles. The second cycle of a write carries the address and data. The second cycle of an erase must carry the confirm code and an address inside the target block. The block checks the supply flag, the sticky supply error and the boot-block lock at that moment. If all of them pass, it pulses a start request to a separate program/erase sequencer. The sequencer reports back through a busy level and a done pulse, with a fail flag that is valid alongside done. An erase can be paused with a suspend request and continued with a resume request.

The status byte holds a ready bit, a suspended bit and three sticky error bits. The ready and suspended bits follow the sequencer. The error bits stay set until a clear command or a reset.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read source is the array (`rd_sel` = 0), `status` reads 80h, and no request output is high.
- R2: From an idle mode (array, identify, status read), FFh selects the array (`rd_sel` 0), 90h selects identify (`rd_sel` 1) and 70h selects status (`rd_sel` 2). Any unlisted code leaves the mode and the status unchanged.
- R3: 40h or 10h arms a write. The next strobe pulses `start_write` for one cycle, with `op_addr`/`op_data` holding its address and data. Until `seq_done`, status bit 7 is 0 and `rd_sel` is 2. On `seq_done` the block enters status read with bit 7 = 1, and `seq_fail` sets bit 4.
- R4: An armed write whose data is FFh in byte mode (`word_mode` = 0), or FFFFh in word mode, is a null write. No start is issued, the mode returns to array read, and the status is unchanged.
- R5: 20h arms an erase. D0h on the next strobe pulses `start_erase` with `op_addr`. Any other code sets bits 5 and 4 and enters status read. When a completed erase reports `seq_fail`, bit 5 is set.
- R6: Status bits 5, 4 and 3 are sticky through all other commands and operations. They are cleared only by 50h, issued from an idle mode, or by a reset.
- R7: `vpp_ok` is sampled only on the data cycle of a write and on the confirm of an erase. If it is low, bit 3 is set, no start is issued and the mode becomes status read.
- R8: While bit 3 is set, a write or erase attempt issues no start. It sets bit 4 (write) or bit 5 (erase) and enters status read.
- R9: A write or erase whose address has upper bits `addr[ADDR_W-1:BOOT_LSB]` equal to `BOOT_TAG` is rejected while `boot_unlock` is low. It sets bit 4 (write) or bit 5 (erase), issues no start and enters status read.
- R10: While a write or erase runs, every command is ignored, except that B0h during an erase pulses `suspend_req` once.
- R11: After the suspend request, once `seq_busy` is low, status reads C0h. In that mode only 70h (`rd_sel` 2), FFh (`rd_sel` 0) and D0h have an effect. D0h pulses `resume_req`, clears bit 6, drops bit 7 and returns to the running erase.
- R12: Status bits 2 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle pulse per completed host write |
| wr_data | input | 16 | Latched write data; command in bits 7:0 |
| wr_addr | input | ADDR_W | Latched write address |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| vpp_ok | input | 1 | Programming supply present |
| boot_unlock | input | 1 | Boot block may be altered |
| seq_busy | input | 1 | Sequencer is executing |
| seq_done | input | 1 | One-cycle pulse at operation end |
| seq_fail | input | 1 | Operation failed, valid with seq_done |
| rd_sel | output | 2 | Read source: 0 array, 1 identify, 2 status |
| status | output | 8 | Status byte |
| start_write | output | 1 | Start a program operation |
| start_erase | output | 1 | Start a block erase |
| suspend_req | output | 1 | Request to pause the erase |
| resume_req | output | 1 | Request to continue the erase |
| op_addr | output | ADDR_W | Operation address |
| op_data | output | 16 | Program data |

## Verification
A wrong mode shows on `rd_sel` and on status bits 7 and 6 in the cycle after the strobe that caused it, so every command is followed by a look at both. A wrong error decision shows as a missing or extra start pulse in that same cycle, or as a wrong sticky bit that persists until the next clear. The bench therefore reads the status after each operation and before it clears. A lost suspend handshake leaves status stuck at busy, and the bench's ready-wait limit turns that into a failed check.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W   = 19,
  parameter int BOOT_LSB = 13,
  parameter int BOOT_TAG = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              word_mode,
  input  logic              vpp_ok,
  input  logic              boot_unlock,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              seq_fail,
  output logic [1:0]        rd_sel,
  output logic [7:0]        status,
  output logic              start_write,
  output logic              start_erase,
  output logic              suspend_req,
  output logic              resume_req,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_data
);
  localparam int TAG_W = ADDR_W - BOOT_LSB;

  typedef enum logic [2:0] {
    M_ARRAY, M_IDENT, M_STAT, M_WARM, M_EARM, M_WRUN, M_ERUN, M_SUSP
  } mode_t;

  mode_t      mode_q;
  logic [2:0] err_q;       // {erase, write, supply}
  logic       pend_q;
  logic       susp_arr_q;

  wire [7:0] cmd     = wr_data[7:0];
  wire       idle    = (mode_q == M_ARRAY) || (mode_q == M_IDENT) || (mode_q == M_STAT);
  wire       running = (mode_q == M_WRUN) || (mode_q == M_ERUN);
  wire       in_boot = (wr_addr[ADDR_W-1:BOOT_LSB] == TAG_W'(BOOT_TAG));
  wire       locked  = in_boot && !boot_unlock;
  wire       null_wr = (cmd == 8'hFF) && (!word_mode || wr_data[15:8] == 8'hFF);

  assign status = {!running, mode_q == M_SUSP, err_q, 3'b000};

  always_comb begin
    case (mode_q)
      M_ARRAY: rd_sel = 2'd0;
      M_IDENT: rd_sel = 2'd1;
      M_SUSP:  rd_sel = susp_arr_q ? 2'd0 : 2'd2;
      default: rd_sel = 2'd2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= M_ARRAY;
      err_q       <= '0;
      pend_q      <= 1'b0;
      susp_arr_q  <= 1'b0;
      start_write <= 1'b0;
      start_erase <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
    end else begin
      start_write <= 1'b0;
      start_erase <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
      case (mode_q)
        M_ARRAY, M_IDENT, M_STAT:
          if (wr_stb)
            case (cmd)
              8'hFF:        mode_q <= M_ARRAY;
              8'h90:        mode_q <= M_IDENT;
              8'h70:        mode_q <= M_STAT;
              8'h50:        err_q  <= '0;
              8'h20:        mode_q <= M_EARM;
              8'h40, 8'h10: mode_q <= M_WARM;
              default: ;
            endcase
        M_WARM:
          if (wr_stb) begin
            op_addr <= wr_addr;
            op_data <= wr_data;
            if (null_wr)      mode_q <= M_ARRAY;
            else begin
              mode_q <= M_STAT;
              if (err_q[0])     err_q[1] <= 1'b1;
              else if (!vpp_ok) err_q[0] <= 1'b1;
              else if (locked)  err_q[1] <= 1'b1;
              else begin
                start_write <= 1'b1;
                mode_q      <= M_WRUN;
              end
            end
          end
        M_EARM:
          if (wr_stb) begin
            op_addr <= wr_addr;
            mode_q  <= M_STAT;
            if (cmd != 8'hD0) err_q[2:1] <= 2'b11;
            else if (err_q[0]) err_q[2] <= 1'b1;
            else if (!vpp_ok)  err_q[0] <= 1'b1;
            else if (locked)   err_q[2] <= 1'b1;
            else begin
              start_erase <= 1'b1;
              pend_q      <= 1'b0;
              mode_q      <= M_ERUN;
            end
          end
        M_WRUN:
          if (seq_done) begin
            mode_q <= M_STAT;
            if (seq_fail) err_q[1] <= 1'b1;
          end
        M_ERUN:
          if (seq_done) begin
            mode_q <= M_STAT;
            pend_q <= 1'b0;
            if (seq_fail) err_q[2] <= 1'b1;
          end else if (pend_q && !seq_busy) begin
            mode_q     <= M_SUSP;
            pend_q     <= 1'b0;
            susp_arr_q <= 1'b0;
          end else if (wr_stb && cmd == 8'hB0 && !pend_q) begin
            suspend_req <= 1'b1;
            pend_q      <= 1'b1;
          end
        M_SUSP:
          if (wr_stb)
            case (cmd)
              8'hFF: susp_arr_q <= 1'b1;
              8'h70: susp_arr_q <= 1'b0;
              8'hD0: begin
                resume_req <= 1'b1;
                mode_q     <= M_ERUN;
              end
              default: ;
            endcase
        default: mode_q <= M_ARRAY;
      endcase
    end
  end

  assert_no_start_on_supply_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |=> !(start_write || start_erase));

  assert_sticky_erase_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !(wr_stb && idle && cmd == 8'h50)) |=> status[5]);

  assert_busy_reads_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |-> rd_sel == 2'd2);

  assert_one_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_write, start_erase, suspend_req, resume_req}));

  assert_suspend_only_erasing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> $past(mode_q == M_ERUN));

  assert_resume_clears_susp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> (!status[6] && !status[7] && $past(status[6])));

  assert_write_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WRUN && !seq_done) |=> mode_q == M_WRUN);

  assert_low_bits_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> status[2:0] == 3'b000);
endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;
  localparam int AW  = 19;
  localparam int LAT = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 0, word_mode = 1, vpp_ok = 1, boot_unlock = 0;
  logic [15:0] wr_data = '0;
  logic [AW-1:0] wr_addr = '0;
  logic seq_busy = 0, seq_done = 0, seq_fail = 0, fail_next = 0;
  logic [1:0] rd_sel;
  logic [7:0] status;
  logic start_write, start_erase, suspend_req, resume_req;
  logic [AW-1:0] op_addr;
  logic [15:0] op_data;
  int checks = 0, fails = 0, rem = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .BOOT_LSB(13), .BOOT_TAG(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .wr_addr(wr_addr),
    .word_mode(word_mode), .vpp_ok(vpp_ok), .boot_unlock(boot_unlock),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_fail(seq_fail),
    .rd_sel(rd_sel), .status(status), .start_write(start_write), .start_erase(start_erase),
    .suspend_req(suspend_req), .resume_req(resume_req), .op_addr(op_addr), .op_data(op_data));

  // sequencer model, driven away from the active edge
  always @(negedge clk) begin
    seq_done = 0;
    if (!rst_n) begin seq_busy = 0; rem = 0; end
    else if (start_write || start_erase) begin seq_busy = 1; rem = LAT; end
    else if (suspend_req) seq_busy = 0;
    else if (resume_req) seq_busy = 1;
    else if (seq_busy) begin
      if (rem <= 1) begin seq_busy = 0; seq_done = 1; seq_fail = fail_next; end
      else rem = rem - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cmd(input logic [15:0] d, input logic [AW-1:0] a = '0);
    wr_stb = 1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60; i++) begin
      if (status[7]) break;
      @(negedge clk);
    end
    chk("R3 ready reached", status[7], 1);
  endtask

  function automatic logic [7:0] exp_stat(input bit er, input bit vpp, input bit lk, input bit fl);
    if (!vpp) return 8'h88;
    if (lk || fl) return er ? 8'hA0 : 8'h90;
    return 8'h80;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset rd_sel", rd_sel, 0);
    chk("R1 no requests", {start_write, start_erase, suspend_req, resume_req}, 0);

    cmd(16'h0090); chk("R2 identify", rd_sel, 1);
    cmd(16'h0070); chk("R2 status read", rd_sel, 2);
    cmd(16'h0033); chk("R2 reserved ignored", rd_sel, 2);
    cmd(16'h00FF); chk("R2 array", rd_sel, 0);
    cmd(16'h00D0); chk("R2 stray confirm ignored", {rd_sel, status}, {2'd0, 8'h80});

    // plain write
    cmd(16'h0040); cmd(16'hA5A5, 19'h12345);
    chk("R3 start pulse", start_write, 1);
    chk("R3 op fields", {op_addr, op_data}, {19'h12345, 16'hA5A5});
    @(negedge clk);
    chk("R3 busy", {status[7], rd_sel}, {1'b0, 2'd2});
    chk("R3 single pulse", start_write, 0);
    cmd(16'h00FF); chk("R10 ignored while writing", {status[7], rd_sel}, {1'b0, 2'd2});
    wait_ready();
    chk("R3 done status", {status, rd_sel}, {8'h80, 2'd2});

    // failing write, sticky
    fail_next = 1;
    cmd(16'h0010); cmd(16'h1234, 19'h40000); wait_ready();
    fail_next = 0;
    chk("R3 write fail bit4", status, 8'h90);
    cmd(16'h00FF); cmd(16'h0090); cmd(16'h0070);
    chk("R6 sticky through commands", status, 8'h90);
    cmd(16'h0050); chk("R6 clear", status, 8'h80);

    // null writes
    word_mode = 1; cmd(16'h0040); cmd(16'hFFFF, 19'h22222);
    chk("R4 null word", {start_write, rd_sel, status}, {1'b0, 2'd0, 8'h80});
    word_mode = 0; cmd(16'h0040); cmd(16'h12FF, 19'h22222);
    chk("R4 null byte", {start_write, rd_sel, status}, {1'b0, 2'd0, 8'h80});
    word_mode = 1; cmd(16'h0040); cmd(16'h00FF, 19'h22222);
    chk("R4 word non-null writes", start_write, 1);
    wait_ready();

    // erase sequencing error
    cmd(16'h0020); cmd(16'h0070);
    chk("R5 bad confirm", {status, rd_sel}, {8'hB0, 2'd2});
    cmd(16'h0050);

    // supply missing then sticky block
    vpp_ok = 0; cmd(16'h0040); cmd(16'h0001, 19'h30000);
    chk("R7 supply missing", {start_write, status}, {1'b0, 8'h88});
    vpp_ok = 1; cmd(16'h0020); cmd(16'h00D0, 19'h30000);
    chk("R8 erase blocked", {start_erase, status}, {1'b0, 8'hA8});
    cmd(16'h0040); cmd(16'h0002, 19'h30000);
    chk("R8 write blocked", {start_write, status}, {1'b0, 8'hB8});
    cmd(16'h0050); chk("R6 clear all", status, 8'h80);

    // boot lock
    boot_unlock = 0; cmd(16'h0040); cmd(16'h0003, 19'h00010);
    chk("R9 boot write locked", {start_write, status}, {1'b0, 8'h90});
    cmd(16'h0050);
    boot_unlock = 1; cmd(16'h0040); cmd(16'h0003, 19'h00010);
    chk("R9 boot write unlocked", start_write, 1);
    wait_ready(); boot_unlock = 0;

    // erase with suspend / resume
    cmd(16'h0020); cmd(16'h00D0, 19'h20000);
    chk("R5 start erase", {start_erase, op_addr}, {1'b1, 19'h20000});
    @(negedge clk);
    cmd(16'h00B0); chk("R10 suspend req", suspend_req, 1);
    @(negedge clk);
    chk("R11 suspended", {status, rd_sel}, {8'hC0, 2'd2});
    cmd(16'h0090); chk("R11 identify refused", {status, rd_sel}, {8'hC0, 2'd2});
    cmd(16'h00FF); chk("R11 array while suspended", rd_sel, 0);
    cmd(16'h0070); chk("R11 status while suspended", rd_sel, 2);
    cmd(16'h00D0);
    chk("R11 resume", {resume_req, status[7:6]}, {1'b1, 2'b00});
    wait_ready();
    chk("R11 erase completes", status, 8'h80);

    fail_next = 1; cmd(16'h0020); cmd(16'h00D0, 19'h50000); wait_ready(); fail_next = 0;
    chk("R5 erase fail bit5", status, 8'hA0);
    cmd(16'h0050);

    // random operations
    for (int it = 0; it < 60; it++) begin
      bit er, vpp, ul, bt, fl, started;
      logic [AW-1:0] a;
      er = $urandom_range(0, 1); vpp = ($urandom_range(0, 3) != 0);
      ul = $urandom_range(0, 1); bt = $urandom_range(0, 1); fl = ($urandom_range(0, 3) == 0);
      a = bt ? AW'($urandom_range(0, 8191)) : AW'(($urandom_range(1, 63) << 13) | $urandom_range(0, 8191));
      vpp_ok = vpp; boot_unlock = ul; fail_next = fl;
      cmd(16'h0050);
      if (er) begin cmd(16'h0020); cmd(16'h00D0, a); started = start_erase; end
      else begin cmd(16'h0040); cmd(16'h5A00 | 16'(it), a); started = start_write; end
      chk("R9 R7 start decision", started, vpp && !(bt && !ul));
      wait_ready();
      chk("R6 random status", status, exp_stat(er, vpp, bt && !ul, fl && vpp && !(bt && !ul)));
      chk("R12 low bits", status[2:0], 0);
      vpp_ok = 1; fail_next = 0;
    end
    finish_run();
  end
endmodule